// File: doc/BRIEF.md
# ECC Double-Buffered Pedestal Store

This block holds per-pixel pedestal values in two equal banks. The data path reads from the bank that is currently active. A slow configuration port rewrites the other bank in the background. When the background rewrite is complete, the controller pulses an update-done input. The request is held until the next frame-start pulse and only then do the two banks change roles. As a result, a single frame never mixes values from both banks.

Every stored word carries Hamming check bits and an overall parity bit (SEC-DED). A read corrects any single-bit error. It flags an uncorrectable result when two bits have flipped. Two saturating event counters record how many reads were corrected and how many were uncorrectable. The configuration port also takes a bit-flip mask, which lets faults be planted in a stored codeword.

The model defaults to 16 words of 16 data bits per bank. This gives a 22-bit codeword: 16 data bits, 5 check bits and 1 overall parity bit.

Top module: `pedbuf_ecc_mem`

## Requirements
- R1: While reset is held and on release: bank 0 is active, no swap is pending, `rd_valid`, `rd_corr`, `rd_uncorr` and `write_error` are low, and both counters are 0.
- R2: A read request sampled at a clock edge yields `rd_valid` high with its data exactly two edges later, and `rd_valid` is low one edge after the request.
- R3: Reads return the word stored at `rd_addr` in the bank that is active when the request is sampled.
- R4: A write whose `cfg_bank` differs from `active_bank` is stored. A write aimed at the active bank leaves that bank unchanged, and it raises `write_error` for one cycle after the write edge.
- R5: An `update_done` pulse is latched, and `active_bank` toggles only at a later edge that samples `frame_start` while the request is pending. A `frame_start` with nothing pending leaves the banks as they are, and so does an `update_done` arriving in that same cycle.
- R6: If `update_done` coincides with the `frame_start` that performs a swap, the new request stays pending and the next `frame_start` swaps again.
- R7: Each bit of `cfg_flip` inverts one of the 22 codeword bits as it is written. With exactly one bit set, the read returns the original data with `rd_corr` high and `rd_uncorr` low.
- R8: With two distinct bits set in `cfg_flip`, the read raises `rd_uncorr` and keeps `rd_corr` low.
- R9: `corr_count` and `uncorr_count` each add one per corrected or uncorrectable read and hold at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame boundary pulse; pending swap executes here |
| update_done | input | 1 | Background rewrite complete, request a swap |
| cfg_we | input | 1 | Background write strobe |
| cfg_bank | input | 1 | Bank targeted by the background write |
| cfg_addr | input | AW (4) | Background write address |
| cfg_data | input | DW (16) | Background write data |
| cfg_flip | input | CW (22) | Codeword bits inverted as the word is stored |
| rd_en | input | 1 | Read request from the data path |
| rd_addr | input | AW (4) | Read address |
| rd_valid | output | 1 | Read data valid, two cycles after the request |
| rd_data | output | DW (16) | Corrected read data |
| rd_corr | output | 1 | This read had a single-bit error that was corrected |
| rd_uncorr | output | 1 | This read had an uncorrectable error |
| active_bank | output | 1 | Bank currently serving reads |
| write_error | output | 1 | Previous write targeted the active bank and was dropped |
| corr_count | output | CNT_W (8) | Saturating count of corrected reads |
| uncorr_count | output | CNT_W (8) | Saturating count of uncorrectable reads |

## Verification
Two pairs of events can fall in the same cycle: a swap request against a frame boundary, and a swap against a background write. To provoke the first, the bench raises `update_done` and `frame_start` together, once with no request pending and once while a request is pending. It then judges `active_bank` over the following frame starts, expecting no swap in the first case and two successive swaps in the second. For the second pair, each write's acceptance is judged against the bench's own model of which bank is active. The bench then reads that word back after the roles change. Every codeword bit position is swept with single and adjacent double faults, and the two counters are compared with arithmetic totals up to and past saturation.

// File: rtl/pedbuf_pkg.sv
package pedbuf_pkg;

    // Number of Hamming check bits needed to protect dw data bits.
    function automatic int chk_bits(int dw);
        int p;
        p = 0;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    // Full SEC-DED codeword width: data, check bits and overall parity.
    function automatic int code_w(int dw);
        return dw + chk_bits(dw) + 1;
    endfunction

endpackage

// File: rtl/pedbuf_hamm_enc.sv
module pedbuf_hamm_enc #(
    parameter int DW = 16,
    localparam int PW = pedbuf_pkg::chk_bits(DW),
    localparam int CW = pedbuf_pkg::code_w(DW)
) (
    input  logic [DW-1:0] data_i,
    output logic [CW-1:0] code_o
);

    // Bit 0 holds overall parity; positions that are powers of two hold check bits.
    always_comb begin
        logic [CW-1:0] c;
        int di;
        c  = '0;
        di = 0;
        for (int pos = 1; pos < CW; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                c[pos] = data_i[di];
                di++;
            end
        end
        for (int p = 0; p < PW; p++) begin
            logic par;
            par = 1'b0;
            for (int pos = 1; pos < CW; pos++) begin
                if (((pos >> p) & 1) != 0) par ^= c[pos];
            end
            c[1 << p] = par;
        end
        c[0]   = ^c[CW-1:1];
        code_o = c;
    end

endmodule

// File: rtl/pedbuf_hamm_dec.sv
module pedbuf_hamm_dec #(
    parameter int DW = 16,
    localparam int PW = pedbuf_pkg::chk_bits(DW),
    localparam int CW = pedbuf_pkg::code_w(DW)
) (
    input  logic [CW-1:0] code_i,
    output logic [DW-1:0] data_o,
    output logic          corr_o,
    output logic          uncorr_o
);

    always_comb begin
        logic [PW-1:0] syn;
        logic [CW-1:0] fixed;
        logic          ovr;
        int            di;
        syn = '0;
        for (int p = 0; p < PW; p++) begin
            for (int pos = 1; pos < CW; pos++) begin
                if (((pos >> p) & 1) != 0) syn[p] ^= code_i[pos];
            end
        end
        ovr      = ^code_i;
        fixed    = code_i;
        corr_o   = 1'b0;
        uncorr_o = 1'b0;
        if (ovr) begin
            // Odd weight: a single flip at the syndrome position, if it exists.
            if (int'(syn) < CW) begin
                for (int pos = 0; pos < CW; pos++) begin
                    if (pos == int'(syn)) fixed[pos] = ~fixed[pos];
                end
                corr_o = 1'b1;
            end else begin
                uncorr_o = 1'b1;
            end
        end else if (syn != '0) begin
            uncorr_o = 1'b1;
        end
        data_o = '0;
        di     = 0;
        for (int pos = 1; pos < CW; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                data_o[di] = fixed[pos];
                di++;
            end
        end
    end

endmodule

// File: rtl/pedbuf_ecc_mem.sv
module pedbuf_ecc_mem #(
    parameter int DW    = 16,
    parameter int AW    = 4,
    parameter int CNT_W = 8,
    localparam int CW    = pedbuf_pkg::code_w(DW),
    localparam int DEPTH = 1 << AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             update_done,
    input  logic             cfg_we,
    input  logic             cfg_bank,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [DW-1:0]    cfg_data,
    input  logic [CW-1:0]    cfg_flip,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    output logic             rd_corr,
    output logic             rd_uncorr,
    output logic             active_bank,
    output logic             write_error,
    output logic [CNT_W-1:0] corr_count,
    output logic [CNT_W-1:0] uncorr_count
);

    typedef struct packed {
        logic             active;
        logic             pend;
        logic             wr_err;
        logic             s1_vld;
        logic [CW-1:0]    s1_code;
        logic             o_vld;
        logic [DW-1:0]    o_data;
        logic             o_corr;
        logic             o_unc;
        logic [CNT_W-1:0] corr_cnt;
        logic [CNT_W-1:0] unc_cnt;
    } st_t;

    st_t st_d, st_q;

    logic [CW-1:0] mem_q [2][DEPTH];
    logic [CW-1:0] enc_code;
    logic [DW-1:0] dec_data;
    logic          dec_corr, dec_unc;
    logic          wr_ok;

    pedbuf_hamm_enc #(.DW(DW)) u_enc (
        .data_i (cfg_data),
        .code_o (enc_code)
    );

    pedbuf_hamm_dec #(.DW(DW)) u_dec (
        .code_i   (st_q.s1_code),
        .data_o   (dec_data),
        .corr_o   (dec_corr),
        .uncorr_o (dec_unc)
    );

    assign wr_ok = cfg_we && (cfg_bank != st_q.active);

    always_comb begin
        st_d        = st_q;
        st_d.wr_err = cfg_we && (cfg_bank == st_q.active);
        // Swap only on a frame boundary with a request already latched.
        if (frame_start && st_q.pend) st_d.active = ~st_q.active;
        st_d.pend   = (st_q.pend && !frame_start) || update_done;
        // Stage 1: raw codeword from the bank active at request time.
        st_d.s1_vld = rd_en;
        if (rd_en) st_d.s1_code = mem_q[st_q.active][rd_addr];
        // Stage 2: corrected data and event flags.
        st_d.o_vld  = st_q.s1_vld;
        st_d.o_corr = st_q.s1_vld && dec_corr;
        st_d.o_unc  = st_q.s1_vld && dec_unc;
        if (st_q.s1_vld) st_d.o_data = dec_data;
        if (st_q.s1_vld && dec_corr && (st_q.corr_cnt != '1))
            st_d.corr_cnt = st_q.corr_cnt + 1'b1;
        if (st_q.s1_vld && dec_unc && (st_q.unc_cnt != '1))
            st_d.unc_cnt = st_q.unc_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem_q[cfg_bank][cfg_addr] <= enc_code ^ cfg_flip;
    end

    assign rd_valid     = st_q.o_vld;
    assign rd_data      = st_q.o_data;
    assign rd_corr      = st_q.o_corr;
    assign rd_uncorr    = st_q.o_unc;
    assign active_bank  = st_q.active;
    assign write_error  = st_q.wr_err;
    assign corr_count   = st_q.corr_cnt;
    assign uncorr_count = st_q.unc_cnt;

    // R2
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> ##2 rd_valid);

    // R4
    reject_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_bank == active_bank) |=> write_error);

    // R4
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        write_error |-> $past(cfg_we));

    // R5
    swap_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_bank != $past(active_bank)) |-> $past(frame_start));

    // R8
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_corr && rd_uncorr));

    // R9
    corr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_count == '1) |=> (corr_count == '1));

    // R9
    unc_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uncorr_count == '1) |=> (uncorr_count == '1));

endmodule

// File: tb/pedbuf_ecc_mem_test.sv
`timescale 1ns/1ps
module pedbuf_ecc_mem_test;

    localparam int DW = 16;
    localparam int AW = 4;
    localparam int CW = 22;
    localparam int NW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0, update_done = 1'b0;
    logic          cfg_we = 1'b0, cfg_bank = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [DW-1:0] cfg_data = '0;
    logic [CW-1:0] cfg_flip = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_valid, rd_corr, rd_uncorr, active_bank, write_error;
    logic [DW-1:0] rd_data;
    logic [7:0]    corr_count, uncorr_count;

    int  errors = 0;
    int  checks = 0;
    bit  done = 0;
    logic act_m = 1'b0;

    always #2.5 clk = ~clk;

    pedbuf_ecc_mem uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .update_done(update_done),
        .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .cfg_flip(cfg_flip), .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_corr(rd_corr), .rd_uncorr(rd_uncorr),
        .active_bank(active_bank), .write_error(write_error),
        .corr_count(corr_count), .uncorr_count(uncorr_count)
    );

    function automatic logic [DW-1:0] pat_a(int a);
        return DW'(a * 16'h1357 + 16'h00A1);
    endfunction
    function automatic logic [DW-1:0] pat_b(int a);
        return DW'(~(a * 16'h0F0F) ^ 16'h5A5A);
    endfunction
    function automatic logic [DW-1:0] pat_c(int p);
        return DW'(p * 16'h2469 + 16'h1111);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic bank, int a, logic [DW-1:0] d, logic [CW-1:0] flip);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bank = bank; cfg_addr = AW'(a); cfg_data = d; cfg_flip = flip;
        @(negedge clk);
        cfg_we = 1'b0; cfg_flip = '0;
        chk("R4 write_error", 32'(write_error), 32'(bank == act_m));
        if (bank == act_m) begin
            @(negedge clk);
            chk("R4 write_error one cycle", 32'(write_error), 32'd0);
        end
    endtask

    task automatic rd(int a, output logic [DW-1:0] d, output logic c, output logic u);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
        chk("R2 not valid after one edge", 32'(rd_valid), 32'd0);
        @(negedge clk);
        chk("R2 valid after two edges", 32'(rd_valid), 32'd1);
        d = rd_data; c = rd_corr; u = rd_uncorr;
    endtask

    // Drive update_done and/or frame_start for one cycle, then check the bank.
    task automatic pulse(logic upd, logic fs, logic expect_swap, string req);
        @(negedge clk);
        update_done = upd; frame_start = fs;
        @(negedge clk);
        update_done = 1'b0; frame_start = 1'b0;
        if (expect_swap) act_m = ~act_m;
        chk(req, 32'(active_bank), 32'(act_m));
    endtask

    task automatic swap();
        pulse(1'b1, 1'b0, 1'b0, "R5 request alone keeps bank");
        pulse(1'b0, 1'b1, 1'b1, "R5 swap at frame_start");
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        logic c, u;
        int ce, ue;
        ce = 0; ue = 0;
        repeat (4) @(negedge clk);
        // R1: state during reset and after release
        chk("R1 active in reset", 32'(active_bank), 32'd0);
        chk("R1 write_error in reset", 32'(write_error), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 active", 32'(active_bank), 32'd0);
        chk("R1 rd_valid", 32'(rd_valid), 32'd0);
        chk("R1 flags", 32'({rd_corr, rd_uncorr, write_error}), 32'd0);
        chk("R1 counters", 32'({corr_count, uncorr_count}), 32'd0);
        pulse(1'b0, 1'b1, 1'b0, "R1 R5 no pending after reset");

        // Fill background bank 1, swap it in, read it back (R3, R4, R5)
        for (int a = 0; a < NW; a++) wr(1'b1, a, pat_a(a), '0);
        swap();
        for (int a = 0; a < NW; a++) begin
            rd(a, d, c, u);
            chk("R3 data bank1", 32'(d), 32'(pat_a(a)));
            chk("R3 clean flags", 32'({c, u}), 32'd0);
        end
        // Write aimed at active bank is dropped (R4)
        wr(1'b1, 3, ~pat_a(3), '0);
        rd(3, d, c, u);
        chk("R4 active bank unchanged", 32'(d), 32'(pat_a(3)));

        // Fill bank 0 in the background while bank 1 serves
        for (int a = 0; a < NW; a++) wr(1'b0, a, pat_b(a), '0);
        // R5: request and boundary together with nothing pending: no swap
        pulse(1'b1, 1'b1, 1'b0, "R5 coincident with nothing pending");
        // R6: swap while a new request arrives in the same cycle
        pulse(1'b1, 1'b1, 1'b1, "R6 swap with coincident request");
        for (int a = 0; a < NW; a++) begin
            rd(a, d, c, u);
            chk("R3 data bank0", 32'(d), 32'(pat_b(a)));
        end
        pulse(1'b0, 1'b1, 1'b1, "R6 kept request swaps again");
        rd(5, d, c, u);
        chk("R3 R6 back on bank1", 32'(d), 32'(pat_a(5)));
        pulse(1'b0, 1'b1, 1'b0, "R5 no request no swap");

        // R7: single flip at every codeword position
        for (int p = 0; p < CW; p++) begin
            wr(~act_m, p % NW, pat_c(p), CW'(1) << p);
            swap();
            rd(p % NW, d, c, u);
            ce++;
            chk($sformatf("R7 corrected data pos %0d", p), 32'(d), 32'(pat_c(p)));
            chk("R7 corr flag", 32'({c, u}), 32'b10);
            chk("R9 corr_count", 32'(corr_count), 32'(ce));
        end
        // R8: two adjacent flips at every position
        for (int p = 0; p < CW; p++) begin
            wr(~act_m, p % NW, pat_c(p), (CW'(1) << p) | (CW'(1) << ((p + 1) % CW)));
            swap();
            rd(p % NW, d, c, u);
            ue++;
            chk($sformatf("R8 uncorr flag pos %0d", p), 32'({c, u}), 32'b01);
            chk("R9 uncorr_count", 32'(uncorr_count), 32'(ue));
        end
        // R9: saturation of the uncorrectable counter
        for (int i = 0; i < 240; i++) begin
            rd((CW - 1) % NW, d, c, u);
            ue++;
        end
        chk("R9 uncorr saturates", 32'(uncorr_count), 32'(ue > 255 ? 255 : ue));
        // R9: saturation of the corrected counter
        wr(~act_m, 7, pat_c(99), CW'(1) << 9);
        swap();
        for (int i = 0; i < 240; i++) begin
            rd(7, d, c, u);
            ce++;
        end
        chk("R7 R9 data on repeated correction", 32'(d), 32'(pat_c(99)));
        chk("R9 corr saturates", 32'(corr_count), 32'(ce > 255 ? 255 : ce));
        chk("R9 uncorr held", 32'(uncorr_count), 32'd255);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule